// File: doc/BRIEF.md
# Coherency Port Snoop Enable Controller

This block sits between the request sources of a coherent interconnect and its slave ports. It decides, port by port, whether snoop requests and distributed-virtual-memory (DVM) message requests may be forwarded. There are five slave ports: two full-coherency ports and three lite ports. Software sets a two-bit enable field for each port through a small memory-mapped register bus.

An enable change does not complete at once. Each port raises a pending flag when its enables change, and a single shared status bit shows whether any port is still settling. Turning traffic on settles after a fixed two-cycle handshake. Turning a kind of traffic off settles only after every request of that kind already forwarded to the port has been acknowledged. Software polls the status bit until it reads zero.

The block also keeps a count of outstanding forwarded requests for each port and each traffic kind. A request is held back while its count is at its ceiling.

Top module: `snoop_gate_ctrl`

## Requirements
- R1: After reset every port's enable field reads 0, the status bit reads 0, and no snoop or DVM valid is forwarded even when requests are present.
- R2: Port p (0..4, the two full-coherency ports first) has its control register at byte address 16*(p+1). Bit 0 is the snoop enable and bit 1 is the DVM enable. A read returns those two bits in [1:0] with zeros above, and write data above bit 1 is dropped.
- R3: A port's snoop valid output is high exactly when its snoop request input is high, its snoop enable is set, and its outstanding snoop count is below the ceiling. DVM works the same way with bit 1, and the gating follows the register from the cycle after the write edge.
- R4: The status register at byte address 0x0C returns in bit 0 the OR of all port pending flags, with zeros above.
- R5: A write that sets an enable bit and clears none raises the port's pending flag. The status reads 1 after the write edge and after the next edge, and reads 0 after the second edge following the write.
- R6: A write that clears an enable bit keeps the pending flag set until the outstanding count of every cleared kind is zero. The flag drops on the first edge at which that count was already zero, which is the edge after the write when nothing is outstanding.
- R7: Each port keeps a separate outstanding count for each kind. A forwarded request adds one, an acknowledge of that kind subtracts one, and an acknowledge that arrives while the count is zero is ignored.
- R8: With a 4-bit count, a port with 15 outstanding requests of a kind forwards no further request of that kind until an acknowledge lowers the count.
- R9: Writing the value a control register already holds raises no pending flag. Writes to the status address or to any unmapped address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| snp_req_i | input | 5 | Snoop request per port |
| dvm_req_i | input | 5 | DVM message request per port |
| snp_ack_i | input | 5 | Snoop acknowledge per port |
| dvm_ack_i | input | 5 | DVM acknowledge per port |
| snp_vld_o | output | 5 | Gated snoop valid per port |
| dvm_vld_o | output | 5 | Gated DVM valid per port |

## Verification
The assertions check several rules on every cycle:
- a forwarded valid always has a request behind it;
- a pending flag rises only after a register write;
- a flag drops only once the cleared kinds have drained;
- a counter at its ceiling never receives a forward;
- an acknowledge at zero leaves the count at zero;
- the status read reflects every pending port.

Only the bench scenarios can show the exact two-cycle settle time of an enable, the drain edge after the final acknowledge, and the count limit of fifteen. The same holds for the fact that spurious acknowledges do not disturb a later drain and that ignored writes leave registers unchanged.

// File: rtl/snoop_gate_pkg.sv
package snoop_gate_pkg;

  localparam int EN_W       = 2;
  localparam int KIND_SNP   = 0;
  localparam int KIND_DVM   = 1;
  localparam int unsigned STATUS_WIN = 0;
  localparam int unsigned STATUS_OFF = 'hC;
  localparam int unsigned CTRL_OFF   = 0;
  localparam int unsigned PORT_WIN0  = 1;

  typedef logic [EN_W-1:0] en_t;

  function automatic logic addr_is(input logic [31:0] addr,
                                   input int unsigned win,
                                   input int unsigned off,
                                   input int unsigned wbits);
    return addr == 32'((win << wbits) + off);
  endfunction

  function automatic en_t dropped_bits(input en_t cur, input en_t nxt);
    return cur & ~nxt;
  endfunction

  function automatic en_t raised_bits(input en_t cur, input en_t nxt);
    return nxt & ~cur;
  endfunction

endpackage

// File: rtl/sg_counter.sv
module sg_counter #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  input  logic dec_i,
  output logic full_o,
  output logic busy_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             dec_eff;

  assign dec_eff = dec_i && (cnt_q != '0);
  assign full_o  = (cnt_q == CNT_MAX);
  assign busy_o  = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + CNT_W'(inc_i) - CNT_W'(dec_eff);
  end

  // R7
  zero_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && dec_i && !inc_i) |=> (cnt_q == '0));

  // R8
  no_forward_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |-> !inc_i);

endmodule

// File: rtl/sg_port.sv
module sg_port import snoop_gate_pkg::*; #(
  parameter int CNT_W  = 4,
  parameter int EN_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  en_t  wval_i,
  input  logic snp_req_i,
  input  logic dvm_req_i,
  input  logic snp_ack_i,
  input  logic dvm_ack_i,
  output logic snp_vld_o,
  output logic dvm_vld_o,
  output en_t  en_o,
  output logic pend_o
);
  localparam int TMR_W = $clog2(EN_LAT + 1);

  en_t             en_q, drain_q;
  logic [TMR_W-1:0] tmr_q;
  logic            pend_q;

  en_t req, ack, vld, full, busy;
  en_t lost, gained;
  logic change, drained;

  assign req = {dvm_req_i, snp_req_i};
  assign ack = {dvm_ack_i, snp_ack_i};

  genvar k;
  generate
    for (k = 0; k < EN_W; k++) begin : g_kind
      assign vld[k] = req[k] && en_q[k] && !full[k];
      sg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (vld[k]),
        .dec_i (ack[k]),
        .full_o(full[k]),
        .busy_o(busy[k])
      );
    end
  endgenerate

  assign snp_vld_o = vld[KIND_SNP];
  assign dvm_vld_o = vld[KIND_DVM];
  assign en_o      = en_q;
  assign pend_o    = pend_q;

  assign lost    = dropped_bits(en_q, wval_i);
  assign gained  = raised_bits(en_q, wval_i);
  assign change  = wr_i && (wval_i != en_q);
  assign drained = ~|(drain_q & busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (wr_i) en_q <= wval_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      drain_q <= '0;
      tmr_q   <= '0;
    end else if (change) begin
      pend_q  <= 1'b1;
      drain_q <= (pend_q ? drain_q : en_t'(0)) | lost;
      if (|gained)     tmr_q <= TMR_W'(EN_LAT - 1);
      else if (!pend_q) tmr_q <= '0;
    end else if (pend_q) begin
      if (tmr_q != '0) tmr_q <= tmr_q - 1'b1;
      else if (drained) begin
        pend_q  <= 1'b0;
        drain_q <= '0;
      end
    end
  end

  // R5
  pend_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(wr_i));

  // R6
  drop_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> ($past(drain_q & busy) == '0));

  // R3
  snp_off_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_i && !wval_i[KIND_SNP]) |-> !snp_vld_o);

endmodule

// File: rtl/sg_regif.sv
module sg_regif import snoop_gate_pkg::*; #(
  parameter int NUM_PORTS = 5,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int WIN_BITS  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  en_t  [NUM_PORTS-1:0]     en_i,
  input  logic [NUM_PORTS-1:0]     pend_i,
  output logic [NUM_PORTS-1:0]     port_wr_o,
  output en_t                      wval_o,
  output logic [DATA_W-1:0]        rdata_o
);
  logic [NUM_PORTS-1:0] port_hit;
  logic                 sts_hit;
  logic                 unused_hi;

  assign sts_hit   = addr_is(32'(addr_i), STATUS_WIN, STATUS_OFF, WIN_BITS);
  assign wval_o    = wdata_i[EN_W-1:0];
  assign unused_hi = ^wdata_i[DATA_W-1:EN_W];

  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_dec
      assign port_hit[p]  = addr_is(32'(addr_i), PORT_WIN0 + p, CTRL_OFF, WIN_BITS);
      assign port_wr_o[p] = we_i && port_hit[p];
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    if (sts_hit) rdata_o[0] = |pend_i;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (port_hit[i]) rdata_o[EN_W-1:0] = en_i[i];
    end
  end

  // R2
  single_port_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_wr_o));

  // R4
  status_reflects_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_hit && |pend_i) |-> rdata_o[0]);

endmodule

// File: rtl/snoop_gate_ctrl.sv
module snoop_gate_ctrl import snoop_gate_pkg::*; #(
  parameter int N_FULL   = 2,
  parameter int N_LITE   = 3,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int WIN_BITS = 4,
  parameter int CNT_W    = 4,
  parameter int EN_LAT   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  input  logic [N_FULL+N_LITE-1:0] snp_req_i,
  input  logic [N_FULL+N_LITE-1:0] dvm_req_i,
  input  logic [N_FULL+N_LITE-1:0] snp_ack_i,
  input  logic [N_FULL+N_LITE-1:0] dvm_ack_i,
  output logic [N_FULL+N_LITE-1:0] snp_vld_o,
  output logic [N_FULL+N_LITE-1:0] dvm_vld_o
);
  localparam int NUM_PORTS = N_FULL + N_LITE;

  logic [NUM_PORTS-1:0] port_wr;
  logic [NUM_PORTS-1:0] port_pend;
  en_t  [NUM_PORTS-1:0] port_en;
  en_t                  wval;

  sg_regif #(
    .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BITS(WIN_BITS)
  ) u_regif (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (reg_we),
    .addr_i   (reg_addr),
    .wdata_i  (reg_wdata),
    .en_i     (port_en),
    .pend_i   (port_pend),
    .port_wr_o(port_wr),
    .wval_o   (wval),
    .rdata_o  (reg_rdata)
  );

  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_port
      sg_port #(.CNT_W(CNT_W), .EN_LAT(EN_LAT)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (port_wr[p]),
        .wval_i   (wval),
        .snp_req_i(snp_req_i[p]),
        .dvm_req_i(dvm_req_i[p]),
        .snp_ack_i(snp_ack_i[p]),
        .dvm_ack_i(dvm_ack_i[p]),
        .snp_vld_o(snp_vld_o[p]),
        .dvm_vld_o(dvm_vld_o[p]),
        .en_o     (port_en[p]),
        .pend_o   (port_pend[p])
      );

      // R3
      snp_vld_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_vld_o[p] |-> snp_req_i[p]);

      // R3
      dvm_vld_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dvm_vld_o[p] |-> dvm_req_i[p]);
    end
  endgenerate

endmodule

// File: tb/snoop_gate_ctrl_tb.sv
`timescale 1ns/1ps
module snoop_gate_ctrl_tb;
  localparam int NP = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NP-1:0] snp_req = '0, dvm_req = '0, snp_ack = '0, dvm_ack = '0;
  logic [NP-1:0] snp_vld, dvm_vld;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  snoop_gate_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .snp_req_i(snp_req), .dvm_req_i(dvm_req),
    .snp_ack_i(snp_ack), .dvm_ack_i(dvm_ack),
    .snp_vld_o(snp_vld), .dvm_vld_o(dvm_vld)
  );

  typedef struct packed {
    logic [2:0] port; logic [1:0] cfg;
    logic sreq; logic dreq; logic esnp; logic edvm;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{3'd0, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1},
    '{3'd1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0},
    '{3'd2, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1},
    '{3'd3, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{3'd4, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0},
    '{3'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{3'd4, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1},
    '{3'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  function automatic logic [7:0] ctrl_addr(input int p);
    return 8'(16 * (p + 1));
  endfunction

  localparam logic [7:0] STS_ADDR = 8'h0C;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #0.2; d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 40; i++) begin
      rd(STS_ADDR, s);
      if (s[0] == 1'b0) break;
      tick();
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1 reset state
    for (int p = 0; p < NP; p++) begin
      rd(ctrl_addr(p), d); chk("R1 ctrl after reset", d, 32'h0);
    end
    rd(STS_ADDR, d); chk("R1 status after reset", d, 32'h0);
    snp_req = '1; dvm_req = '1; #0.2;
    chk("R1 no snoop valid", 32'(snp_vld), 32'h0);
    chk("R1 no dvm valid", 32'(dvm_vld), 32'h0);
    snp_req = '0; dvm_req = '0;
    tick();

    // R2 / R3 vector table
    foreach (VEC[i]) begin
      wr(ctrl_addr(int'(VEC[i].port)), {30'h2BCD_0A5C, VEC[i].cfg});
      wait_idle();
      rd(ctrl_addr(int'(VEC[i].port)), d);
      chk("R2 ctrl readback", d, 32'(VEC[i].cfg));
      snp_req[VEC[i].port] = VEC[i].sreq;
      dvm_req[VEC[i].port] = VEC[i].dreq;
      #0.2;
      chk("R3 snoop gating", 32'(snp_vld), 32'(VEC[i].esnp) << VEC[i].port);
      chk("R3 dvm gating", 32'(dvm_vld), 32'(VEC[i].edvm) << VEC[i].port);
      snp_req = '0; dvm_req = '0;
      tick();
    end

    // R5 enable settles two cycles after write (port 2 holds 2)
    wr(ctrl_addr(2), 32'h3);
    rd(STS_ADDR, d); chk("R5 pending after write edge", d, 32'h1);
    tick(); rd(STS_ADDR, d); chk("R5 pending one edge later", d, 32'h1);
    tick(); rd(STS_ADDR, d); chk("R5 clear two edges later", d, 32'h0);

    // R9 same value, status write, unmapped write
    wr(ctrl_addr(2), 32'h3);
    rd(STS_ADDR, d); chk("R9 same value no pending", d, 32'h0);
    wr(8'h70, 32'h0);
    rd(ctrl_addr(2), d); chk("R9 unmapped write ignored", d, 32'h3);
    wr(STS_ADDR, 32'hFFFF_FFFF);
    rd(STS_ADDR, d); chk("R9 status write ignored", d, 32'h0);
    rd(ctrl_addr(0), d); chk("R9 status write leaves ctrl", d, 32'h0);

    // R6 disable with nothing outstanding (port 1 holds 3)
    wr(ctrl_addr(1), 32'h1);
    rd(STS_ADDR, d); chk("R6 pending after disable", d, 32'h1);
    tick(); rd(STS_ADDR, d); chk("R6 idle drain clears next edge", d, 32'h0);

    // R7 spurious acks at zero, then drain of three snoops on port 0
    wr(ctrl_addr(0), 32'h1);
    wait_idle();
    snp_ack[0] = 1'b1; tick(); tick(); snp_ack[0] = 1'b0;
    snp_req[0] = 1'b1; tick(); tick(); tick(); snp_req[0] = 1'b0;
    wr(ctrl_addr(0), 32'h0);
    rd(STS_ADDR, d); chk("R6 pending with outstanding", d, 32'h1);
    snp_ack[0] = 1'b1;
    tick(); rd(STS_ADDR, d); chk("R7 pending after first ack", d, 32'h1);
    tick(); rd(STS_ADDR, d); chk("R7 pending after second ack", d, 32'h1);
    tick(); snp_ack[0] = 1'b0;
    rd(STS_ADDR, d); chk("R7 pending at final ack edge", d, 32'h1);
    tick(); rd(STS_ADDR, d); chk("R6 clear after drain", d, 32'h0);

    // R8 ceiling of 15 outstanding DVM on port 3
    wr(ctrl_addr(3), 32'h2);
    wait_idle();
    dvm_req[3] = 1'b1;
    for (int i = 0; i < 14; i++) tick();
    #0.2; chk("R8 forward at 14 outstanding", 32'(dvm_vld[3]), 32'h1);
    tick(); #0.2; chk("R8 held at 15 outstanding", 32'(dvm_vld[3]), 32'h0);
    dvm_ack[3] = 1'b1; tick(); dvm_ack[3] = 1'b0; #0.2;
    chk("R8 forward after ack", 32'(dvm_vld[3]), 32'h1);
    dvm_req[3] = 1'b0;
    tick();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule